// File: doc/BRIEF.md
# FP32 Operand and Result Modifier Unit

This unit wraps the floating-point modifiers that a vector ALU applies around its arithmetic core. On the way in, each of up to three single-precision operands can have its magnitude taken and its sign flipped. On the way out, the raw result can be scaled by a power of two (x2, x4 or x0.5) and then clamped into the unit interval. Both sides share one register stage, and a valid bit travels alongside the data.

The output scaling does not use a multiplier. It moves the exponent, and it handles subnormal inputs and outputs exactly. Halving rounds to nearest-even, and doubling saturates to an infinity of the correct sign. Zero, infinity and NaN inputs pass through the scaler unchanged. The modifiers always apply in the same order. Absolute value comes before negation on the source side. Scaling comes before clamping on the result side.

Top module: `fpmod_unit`

## Requirements
- R1: `vld_o` equals `vld_i` from one clock earlier. A synchronous `rst` clears `vld_o`, every `opnd_o` lane and `res_o` to zero.
- R2: When `opnd_abs_i[i]` is set, bit 31 of lane i is cleared. Bits 30:0 of every lane, including NaN payloads, always pass through unchanged.
- R3: When `opnd_neg_i[i]` is set, bit 31 of lane i is inverted after the absolute-value step. With both bits set, the lane comes out with bit 31 = 1.
- R4: With `omod_i` = 0 and `clamp_i` = 0, `res_o` equals `raw_res_i` bit for bit.
- R5: Codes `omod_i` = 1 (x2) and `omod_i` = 2 (x4) scale a finite nonzero value exactly when the result stays finite. This includes subnormal inputs that become normal.
- R6: When scaling up pushes the biased exponent (bits 30:23) to 255 or more, the result is an infinity that keeps the input's sign.
- R7: Code `omod_i` = 3 halves the value. A result that becomes subnormal is rounded to nearest with ties to even, and a rounding carry may produce the smallest normal.
- R8: Zeros (exponent 0, mantissa 0), infinities and NaNs (exponent 255) leave the scaler unchanged under every code.
- R9: With `clamp_i` = 1, any NaN and any value with bit 31 set, including -0.0 and -inf, gives +0.0 (32'h00000000).
- R10: With `clamp_i` = 1, a value at or above 1.0, including +inf, gives 32'h3F800000. Values in [+0.0, 1.0) pass unchanged.
- R11: When both are enabled, scaling is applied before clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Input data valid |
| opnd_i | input | NUM_SRC x 32 | Source operands, lane i at [i] |
| opnd_abs_i | input | NUM_SRC | Per-lane absolute-value enable |
| opnd_neg_i | input | NUM_SRC | Per-lane negate enable |
| raw_res_i | input | 32 | Unmodified ALU result |
| omod_i | input | 2 | Output scale: 0 none, 1 x2, 2 x4, 3 x0.5 |
| clamp_i | input | 1 | Clamp result to [0.0, 1.0] |
| vld_o | output | 1 | Output valid, one clock after `vld_i` |
| opnd_o | output | NUM_SRC x 32 | Modified source operands |
| res_o | output | 32 | Final destination value |

## Verification
The hardest cases sit at the exponent 1 / exponent 0 boundary of the halving path. There, a rounding carry must move the value back into the normal range, and an exact tie must round to an even mantissa. No ordinary input lands there by chance. The stimulus table therefore places raw results right at that boundary: mantissas of all ones, odd and even tie patterns, and the smallest subnormal. The table also covers subnormals that become normal when doubled or quadrupled, and values one exponent step below overflow. These rows are paired with the clamp so that the scale-then-clamp order shows up in `res_o`.

// File: rtl/fpmod_pkg.sv
package fpmod_pkg;
    localparam int FP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;

    typedef enum logic [1:0] {
        OM_NONE = 2'd0,
        OM_X2   = 2'd1,
        OM_X4   = 2'd2,
        OM_HALF = 2'd3
    } omod_e;

    localparam logic [FP_W-1:0]  FP_ONE   = 32'h3F80_0000;
    localparam logic [EXP_W-1:0] EXP_SPEC = '1;
endpackage

// File: rtl/fpmod_src.sv
module fpmod_src
    import fpmod_pkg::*;
(
    input  logic [FP_W-1:0] val_i,
    input  logic            abs_i,
    input  logic            neg_i,
    output logic [FP_W-1:0] val_o
);
    logic sign_mag;

    always_comb begin
        // magnitude first, then the sign flip
        sign_mag = abs_i ? 1'b0 : val_i[FP_W-1];
        val_o    = {sign_mag ^ neg_i, val_i[FP_W-2:0]};
    end
endmodule

// File: rtl/fpmod_scale.sv
module fpmod_scale
    import fpmod_pkg::*;
(
    input  logic [FP_W-1:0] val_i,
    input  omod_e           omod_i,
    output logic [FP_W-1:0] val_o
);
    localparam int SH_W = MAN_W + 2;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             is_spec;
    logic             is_zero;
    logic [1:0]       up_k;
    logic [SH_W-1:0]  sh;
    logic [EXP_W:0]   ex_up;
    logic [MAN_W:0]   half_full;
    logic [MAN_W-1:0] half_q;
    logic [MAN_W:0]   half_r;

    always_comb begin
        sgn     = val_i[FP_W-1];
        ex      = val_i[FP_W-2:MAN_W];
        mn      = val_i[MAN_W-1:0];
        is_spec = (ex == EXP_SPEC);
        is_zero = (ex == '0) && (mn == '0);
        up_k    = (omod_i == OM_X2) ? 2'd1 : 2'd2;

        // subnormal scaled up: shift the mantissa and renormalise
        sh    = {2'b00, mn} << up_k;
        ex_up = {1'b0, ex} + {{(EXP_W-1){1'b0}}, up_k};

        // halving near the bottom of the range: shift right, round half to even
        half_full = {ex[0], mn};
        half_q    = half_full[MAN_W:1];
        half_r    = {1'b0, half_q} + {{MAN_W{1'b0}}, half_full[0] & half_q[0]};

        val_o = val_i;
        unique case (omod_i)
            OM_NONE: val_o = val_i;
            OM_X2, OM_X4: begin
                if (!is_spec && !is_zero) begin
                    if (ex == '0) begin
                        if (sh[SH_W-1])
                            val_o = {sgn, 8'd2, sh[SH_W-2:1]};
                        else if (sh[MAN_W])
                            val_o = {sgn, 8'd1, sh[MAN_W-1:0]};
                        else
                            val_o = {sgn, 8'd0, sh[MAN_W-1:0]};
                    end else if (ex_up >= {1'b0, EXP_SPEC}) begin
                        val_o = {sgn, EXP_SPEC, {MAN_W{1'b0}}};
                    end else begin
                        val_o = {sgn, ex_up[EXP_W-1:0], mn};
                    end
                end
            end
            OM_HALF: begin
                if (!is_spec) begin
                    if (ex <= 8'd1)
                        val_o = {sgn, {(EXP_W-1){1'b0}}, half_r[MAN_W], half_r[MAN_W-1:0]};
                    else
                        val_o = {sgn, ex - 8'd1, mn};
                end
            end
            default: val_o = val_i;
        endcase
    end
endmodule

// File: rtl/fpmod_clamp.sv
module fpmod_clamp
    import fpmod_pkg::*;
(
    input  logic [FP_W-1:0] val_i,
    input  logic            en_i,
    output logic [FP_W-1:0] val_o
);
    logic is_nan;

    always_comb begin
        is_nan = (val_i[FP_W-2:MAN_W] == EXP_SPEC) && (val_i[MAN_W-1:0] != '0);
        if (!en_i)
            val_o = val_i;
        else if (is_nan || val_i[FP_W-1])
            val_o = '0;
        else if (val_i[FP_W-2:0] >= FP_ONE[FP_W-2:0])
            val_o = FP_ONE;
        else
            val_o = val_i;
    end
endmodule

// File: rtl/fpmod_unit.sv
module fpmod_unit
    import fpmod_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          vld_i,
    input  logic [NUM_SRC-1:0][FP_W-1:0]  opnd_i,
    input  logic [NUM_SRC-1:0]            opnd_abs_i,
    input  logic [NUM_SRC-1:0]            opnd_neg_i,
    input  logic [FP_W-1:0]               raw_res_i,
    input  logic [1:0]                    omod_i,
    input  logic                          clamp_i,
    output logic                          vld_o,
    output logic [NUM_SRC-1:0][FP_W-1:0]  opnd_o,
    output logic [FP_W-1:0]               res_o
);
    typedef struct packed {
        logic                         vld;
        logic [NUM_SRC-1:0][FP_W-1:0] ops;
        logic [FP_W-1:0]              res;
    } stage_t;

    stage_t st_d, st_q;

    logic [NUM_SRC-1:0][FP_W-1:0] mod_ops;
    logic [FP_W-1:0]              scaled;
    logic [FP_W-1:0]              clamped;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        fpmod_src u_src (
            .val_i (opnd_i[i]),
            .abs_i (opnd_abs_i[i]),
            .neg_i (opnd_neg_i[i]),
            .val_o (mod_ops[i])
        );
    end

    fpmod_scale u_scale (
        .val_i  (raw_res_i),
        .omod_i (omod_e'(omod_i)),
        .val_o  (scaled)
    );

    fpmod_clamp u_clamp (
        .val_i (scaled),
        .en_i  (clamp_i),
        .val_o (clamped)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        st_d.ops = mod_ops;
        st_d.res = clamped;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign opnd_o = st_q.ops;
    assign res_o  = st_q.res;

    // ---------------- assertions ----------------
    assert_vld_set_R1: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);
    assert_vld_clr_R1: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_abs_sign_R2: assert property (@(posedge clk) disable iff (rst)
            (opnd_abs_i[i] && !opnd_neg_i[i]) |=> !opnd_o[i][FP_W-1]);
        assert_mag_keep_R2: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> opnd_o[i][FP_W-2:0] == $past(opnd_i[i][FP_W-2:0]));
        assert_abs_neg_R3: assert property (@(posedge clk) disable iff (rst)
            (opnd_abs_i[i] && opnd_neg_i[i]) |=> opnd_o[i][FP_W-1]);
    end

    assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (omod_i == 2'd0 && !clamp_i) |=> res_o == $past(raw_res_i));
    assert_special_R8: assert property (@(posedge clk) disable iff (rst)
        (raw_res_i[FP_W-2:MAN_W] == EXP_SPEC && !clamp_i) |=> res_o == $past(raw_res_i));
    assert_clamp_range_R10: assert property (@(posedge clk) disable iff (rst)
        clamp_i |=> res_o <= FP_ONE);
endmodule

// File: tb/sim_fpmod_unit.sv
module sim_fpmod_unit;
    localparam int NS = 3;
    localparam int NV = 28;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  vld_i;
    logic [NS-1:0][31:0]   opnd_i;
    logic [NS-1:0]         opnd_abs_i;
    logic [NS-1:0]         opnd_neg_i;
    logic [31:0]           raw_res_i;
    logic [1:0]            omod_i;
    logic                  clamp_i;
    logic                  vld_o;
    logic [NS-1:0][31:0]   opnd_o;
    logic [31:0]           res_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fpmod_unit #(.NUM_SRC(NS)) u0 (
        .clk(clk), .rst(rst), .vld_i(vld_i), .opnd_i(opnd_i),
        .opnd_abs_i(opnd_abs_i), .opnd_neg_i(opnd_neg_i),
        .raw_res_i(raw_res_i), .omod_i(omod_i), .clamp_i(clamp_i),
        .vld_o(vld_o), .opnd_o(opnd_o), .res_o(res_o)
    );

    // raw result, omod code, clamp, expected result, requirement
    localparam logic [31:0] T_RAW [NV] = '{
        32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h00400000, 32'h00600000,
        32'h7F000000, 32'hFF000000, 32'h7E800000, 32'h00800001, 32'h00800003,
        32'h00FFFFFF, 32'h80000003, 32'h00000001, 32'h7FC12345, 32'hFF800000,
        32'h80000000, 32'h12345678, 32'h7FC00001, 32'hBF800000, 32'h80000000,
        32'h7F800000, 32'h40490FDB, 32'h3F000000, 32'h3F400000, 32'h3FC00000,
        32'h3F800000, 32'h7F7FFFFF, 32'hFF7FFFFF};
    localparam logic [1:0] T_OM [NV] = '{
        2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd3, 2'd3,
        2'd3, 2'd3, 2'd3, 2'd1, 2'd3, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd1, 2'd3, 2'd0, 2'd3, 2'd1};
    localparam logic T_CL [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] T_EXP [NV] = '{
        32'h40000000, 32'h40800000, 32'h3F000000, 32'h00800000, 32'h01400000,
        32'h7F800000, 32'hFF800000, 32'h7F000000, 32'h00400000, 32'h00400002,
        32'h00800000, 32'h80000002, 32'h00000000, 32'h7FC12345, 32'hFF800000,
        32'h80000000, 32'h12345678, 32'h00000000, 32'h00000000, 32'h00000000,
        32'h3F800000, 32'h3F800000, 32'h3F000000, 32'h3F800000, 32'h3F400000,
        32'h3F800000, 32'h7EFFFFFF, 32'h00000000};
    localparam string T_REQ [NV] = '{
        "R5", "R5", "R7", "R5", "R5", "R6", "R6", "R5", "R7", "R7",
        "R7", "R7", "R7", "R8", "R8", "R8", "R4", "R9", "R9", "R9",
        "R10", "R10", "R10", "R11", "R11", "R10", "R7", "R11"};
    // source side: base operand and per-lane abs/neg masks
    localparam logic [31:0] T_SX [4] = '{32'hBF800000, 32'h3F800000, 32'hFFC00123, 32'h80000000};
    localparam logic [2:0]  T_AB [8] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b111, 3'b101, 3'b000, 3'b011};
    localparam logic [2:0]  T_NG [8] = '{3'b000, 3'b000, 3'b011, 3'b100, 3'b111, 3'b010, 3'b111, 3'b110};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // spec of the source side: magnitude first, then flip
    function automatic logic [31:0] src_exp(input logic [31:0] x, input logic a, input logic n);
        return {n ^ (a ? 1'b0 : x[31]), x[30:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; vld_i = 1'b1; opnd_i = '1; opnd_abs_i = '0; opnd_neg_i = '0;
        raw_res_i = 32'hDEADBEEF; omod_i = 2'd0; clamp_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {31'd0, vld_o}, 32'd0);
        chk("R1", res_o, 32'd0);
        for (int i = 0; i < NS; i++) chk("R1", opnd_o[i], 32'd0);
        rst = 1'b0;

        // table walk, one row per cycle
        for (int k = 0; k < NV; k++) begin
            vld_i      = 1'b1;
            raw_res_i  = T_RAW[k];
            omod_i     = T_OM[k];
            clamp_i    = T_CL[k];
            opnd_abs_i = T_AB[k % 8];
            opnd_neg_i = T_NG[k % 8];
            for (int i = 0; i < NS; i++) opnd_i[i] = T_SX[k % 4] + 32'(i);
            @(negedge clk);
            chk(T_REQ[k], res_o, T_EXP[k]);
            chk("R1", {31'd0, vld_o}, 32'd1);
            for (int i = 0; i < NS; i++)
                chk((T_AB[k % 8][i] || T_NG[k % 8][i]) ? "R3" : "R2", opnd_o[i],
                    src_exp(T_SX[k % 4] + 32'(i), T_AB[k % 8][i], T_NG[k % 8][i]));
        end

        // R2: NaN payload kept under abs; R3: abs+neg forces negative
        opnd_i[0] = 32'hFFA5A5A5; opnd_i[1] = 32'h7F812345; opnd_i[2] = 32'h00000001;
        opnd_abs_i = 3'b011; opnd_neg_i = 3'b110;
        @(negedge clk);
        chk("R2", opnd_o[0], 32'h7FA5A5A5);
        chk("R3", opnd_o[1], 32'hFF812345);
        chk("R3", opnd_o[2], 32'h80000001);

        // R1: valid pattern follows with one clock of delay
        begin
            logic [4:0] pat;
            pat = 5'b01101;
            for (int j = 0; j < 5; j++) begin
                vld_i = pat[j];
                @(negedge clk);
                chk("R1", {31'd0, vld_o}, {31'd0, pat[j]});
            end
        end

        // R1: reset in mid-stream clears outputs
        vld_i = 1'b1; raw_res_i = 32'h40000000; omod_i = 2'd0; clamp_i = 1'b0;
        @(negedge clk);
        chk("R4", res_o, 32'h40000000);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, vld_o}, 32'd0);
        chk("R1", res_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, vld_o}, 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule